// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block deserializes a stereo audio stream arriving on three lines: a bit clock, a frame clock that separates the left and right halves of each frame, and a serial data line. The block only receives; all three lines come from an external transmitter. A static 3-bit format code selects one of five framings. Three are right-aligned, where the word ends on the last bit clock before the frame clock changes level, with word lengths of 16, 20 or 24 bits. One is left-aligned 24-bit, where the word starts on the first bit clock of the half-frame. The last is I2S, where the word starts one bit clock after the frame clock edge.

The three lines are brought into the system clock domain with a synchronizer. Data is sampled on the selected bit clock edge. The block counts bit clocks in each half-frame and keeps one shift register shared by all formats. Every completed frame produces one 24-bit two's complement sample per channel. The pair is presented on a valid/ready output port. Two status pins report a format code that is not defined and a number of bit clocks per frame that the selected format does not allow.

The output port cannot stall the serial link, so it has its own back-pressure rules. A completed frame is loaded into the output register only when the register is empty or is being read in the same cycle. A frame that completes while an unread pair is held is dropped. While `out_valid` is high and `out_ready` is low, the held pair does not change. A pair is transferred on every cycle where `out_valid` and `out_ready` are both high.

Top module: `serial_audio_rx`

## Requirements
- R1: `fmt_code` selects the framing: 0 is right-aligned 16-bit, 1 is right-aligned 20-bit, 2 is left-aligned 24-bit, 3 is I2S, and 4 is right-aligned 24-bit.
- R2: Words are received MSB first in two's complement. A right-aligned word shorter than 24 bits is sign-extended to 24 bits on `out_left`/`out_right`.
- R3: In right-aligned formats, only the last N bits of each half-frame are used, where N is the word length. Bits received earlier in the half-frame do not change the output.
- R4: In format 0 at 32 bit clocks per frame, each 16-slot half-frame carries the whole word.
- R5: In formats 2 and 3, a word shorter than 24 bits that is followed by zero bits is delivered as the 24-bit word it forms. A 16-bit word therefore appears shifted left by 8 places, and a 20-bit word shifted left by 4 places.
- R6: In format 3 with `lr_pol`=0, a low frame clock marks the left channel. The MSB arrives one bit clock after the frame clock edge. At 32 bit clocks per frame, each 16-bit word is delivered shifted left by 8 places.
- R7: With `lr_pol`=0, the left channel is marked by a high frame clock in formats 0, 1, 2 and 4, and by a low frame clock in format 3. Setting `lr_pol`=1 inverts this level in every format. With `bclk_pol`=0, data is sampled on the rising bit clock edge; with `bclk_pol`=1, on the falling edge.
- R8: After each completed frame, `rate_err` shows whether the bit clocks in that frame fall outside the allowed range for the format. The allowed ranges are: format 0, 32 to 64; format 1, 40 to 64; formats 2 and 4, 48 to 64; format 3, exactly 32 or 48 to 64. A format code that is not defined allows no rate.
- R9: For `fmt_code` 5, 6 or 7, `fmt_err` is high from the next clock and no pair is made valid.
- R10: Each full frame yields exactly one output pair, with the left and right samples updated together. The partial frame that is under way when reset is released yields nothing.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_left` and `out_right` hold their values, and frames completing during that time are dropped.
- R12: While `rst_n` is low, `out_valid`, `rate_err` and `fmt_err` are cleared on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; much faster than the bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bclk_in | input | 1 | Serial bit clock |
| lrclk_in | input | 1 | Frame clock marking left and right halves |
| sdata_in | input | 1 | Serial audio data |
| fmt_code | input | 3 | Framing select; see R1 |
| lr_pol | input | 1 | Inverts the frame clock level that marks the left channel |
| bclk_pol | input | 1 | 0 samples on the rising bit clock edge, 1 on the falling edge |
| out_valid | output | 1 | A sample pair is held on the output |
| out_ready | input | 1 | The consumer accepts the held pair |
| out_left | output | 24 | Left sample, two's complement |
| out_right | output | 24 | Right sample, two's complement |
| rate_err | output | 1 | Bit clocks per frame outside the allowed range |
| fmt_err | output | 1 | Format code not defined |

## Verification
The assertions assume that `fmt_code`, `lr_pol` and `bclk_pol` change only while `rst_n` is low, and that each bit clock level lasts longer than the synchronizer depth plus one system clock. They also assume the frame clock and data change only on the bit clock edge that is not used for sampling. The bench meets these assumptions as follows. It applies a new configuration only while reset is held. It holds each bit clock level for four system clocks. It drives the frame clock and data on the opposite bit clock edge from the sampling edge.

// File: rtl/sarx_pkg.sv
package sarx_pkg;

  localparam int SAMPLE_W   = 24;
  localparam int SLOT_CNT_W = 7;
  localparam int LEN_SHORT  = 16;
  localparam int LEN_MID    = 20;

  typedef enum logic [2:0] {
    FMT_RJ16 = 3'd0,
    FMT_RJ20 = 3'd1,
    FMT_LJ24 = 3'd2,
    FMT_I2S  = 3'd3,
    FMT_RJ24 = 3'd4
  } fmt_e;

  function automatic logic fmt_known(input logic [2:0] code);
    return code <= 3'd4;
  endfunction

  function automatic logic fmt_right_aligned(input logic [2:0] code);
    return (code == FMT_RJ16) || (code == FMT_RJ20) || (code == FMT_RJ24);
  endfunction

  // Allowed bit clocks per frame for each framing.
  function automatic logic rate_ok(input logic [2:0] code,
                                   input logic [SLOT_CNT_W:0] bits);
    logic ok;
    case (code)
      FMT_RJ16: ok = (bits >= 8'd32) && (bits <= 8'd64);
      FMT_RJ20: ok = (bits >= 8'd40) && (bits <= 8'd64);
      FMT_LJ24,
      FMT_RJ24: ok = (bits >= 8'd48) && (bits <= 8'd64);
      FMT_I2S:  ok = (bits == 8'd32) || ((bits >= 8'd48) && (bits <= 8'd64));
      default:  ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/sarx_sync.sv
module sarx_sync #(
  parameter int STAGES = 2,
  parameter int W      = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) chain[g] <= '0;
      else if (g == 0) chain[g] <= din;
      else chain[g] <= chain[(g == 0) ? 0 : g - 1];
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/sarx_slot_tracker.sv
module sarx_slot_tracker
  import sarx_pkg::*;
#(
  parameter int W     = SAMPLE_W,
  parameter int CNT_W = SLOT_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       fmt_code,
  input  logic             smp,
  input  logic             sbit,
  input  logic             left_now,
  output logic             end_stb,
  output logic             end_left,
  output logic [W-1:0]     end_word,
  output logic [CNT_W-1:0] end_cnt
);

  localparam logic [CNT_W-1:0] FULL    = CNT_W'(W);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [W-1:0]     sr;
  logic [CNT_W-1:0] cnt;
  logic             cur_left;
  logic             started;
  logic             rj;
  logic [W-1:0]     aligned;

  assign rj = fmt_right_aligned(fmt_code);

  // Word of the half-frame that is ending, placed as a 24-bit sample.
  always_comb begin
    aligned = sr;
    if (rj) begin
      case (fmt_code)
        FMT_RJ16: aligned = {{(W-LEN_SHORT){sr[LEN_SHORT-1]}}, sr[LEN_SHORT-1:0]};
        FMT_RJ20: aligned = {{(W-LEN_MID){sr[LEN_MID-1]}}, sr[LEN_MID-1:0]};
        default:  aligned = sr;
      endcase
    end else if (cnt < FULL) begin
      aligned = sr << (FULL - cnt);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr       <= '0;
      cnt      <= '0;
      cur_left <= 1'b0;
      started  <= 1'b0;
      end_stb  <= 1'b0;
      end_left <= 1'b0;
      end_word <= '0;
      end_cnt  <= '0;
    end else begin
      end_stb <= 1'b0;
      if (smp) begin
        if (!started || (left_now != cur_left)) begin
          if (started) begin
            end_stb  <= 1'b1;
            end_left <= cur_left;
            end_word <= aligned;
            end_cnt  <= cnt;
          end
          started  <= 1'b1;
          cur_left <= left_now;
          cnt      <= CNT_W'(1);
          sr       <= {{(W-1){1'b0}}, sbit};
        end else begin
          if (cnt != CNT_TOP) cnt <= cnt + 1'b1;
          if (rj || (cnt < FULL)) sr <= {sr[W-2:0], sbit};
        end
      end
    end
  end

endmodule

// File: rtl/sarx_frame_assembler.sv
module sarx_frame_assembler
  import sarx_pkg::*;
#(
  parameter int W     = SAMPLE_W,
  parameter int CNT_W = SLOT_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       fmt_code,
  input  logic             end_stb,
  input  logic             end_left,
  input  logic [W-1:0]     end_word,
  input  logic [CNT_W-1:0] end_cnt,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [W-1:0]     out_left,
  output logic [W-1:0]     out_right,
  output logic             rate_err
);

  logic [1:0]       ends_seen;
  logic [CNT_W-1:0] left_cnt;
  logic [W-1:0]     left_hold;
  logic [CNT_W:0]   frame_bits;
  logic             frame_done;
  logic             take;

  assign frame_bits = {1'b0, left_cnt} + {1'b0, end_cnt};
  // Two earlier half-frame ends guarantee the held left word is complete.
  assign frame_done = end_stb && !end_left && (ends_seen >= 2'd2);
  assign take       = frame_done && fmt_known(fmt_code) && (!out_valid || out_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ends_seen <= '0;
      left_cnt  <= '0;
      left_hold <= '0;
      rate_err  <= 1'b0;
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
    end else begin
      if (end_stb) begin
        if (ends_seen != 2'd3) ends_seen <= ends_seen + 2'd1;
        if (end_left) begin
          left_hold <= end_word;
          left_cnt  <= end_cnt;
        end
      end
      if (frame_done) rate_err <= !rate_ok(fmt_code, (SLOT_CNT_W+1)'(frame_bits));
      if (take) begin
        out_left  <= left_hold;
        out_right <= end_word;
        out_valid <= 1'b1;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sarx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bclk_in,
  input  logic                lrclk_in,
  input  logic                sdata_in,
  input  logic [2:0]          fmt_code,
  input  logic                lr_pol,
  input  logic                bclk_pol,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SAMPLE_W-1:0] out_left,
  output logic [SAMPLE_W-1:0] out_right,
  output logic                rate_err,
  output logic                fmt_err
);

  localparam int LINES = 3;

  logic [LINES-1:0]      synced;
  logic                  b_s, l_s, d_s, b_q;
  logic                  smp, lr_d, lr_used, is_i2s, left_now;
  logic                  end_stb, end_left;
  logic [SAMPLE_W-1:0]   end_word;
  logic [SLOT_CNT_W-1:0] end_cnt;

  sarx_sync #(.STAGES(SYNC_STAGES), .W(LINES)) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({bclk_in, lrclk_in, sdata_in}),
    .dout (synced)
  );

  assign {b_s, l_s, d_s} = synced;
  assign smp      = bclk_pol ? (b_q & ~b_s) : (~b_q & b_s);
  assign is_i2s   = (fmt_code == FMT_I2S);
  // I2S sees the frame clock one bit late, which turns it into left-aligned.
  assign lr_used  = is_i2s ? lr_d : l_s;
  assign left_now = lr_used ^ lr_pol ^ is_i2s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_q     <= 1'b0;
      lr_d    <= 1'b0;
      fmt_err <= 1'b0;
    end else begin
      b_q     <= b_s;
      fmt_err <= !fmt_known(fmt_code);
      if (smp) lr_d <= l_s;
    end
  end

  sarx_slot_tracker #(.W(SAMPLE_W), .CNT_W(SLOT_CNT_W)) track_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .fmt_code(fmt_code),
    .smp     (smp),
    .sbit    (d_s),
    .left_now(left_now),
    .end_stb (end_stb),
    .end_left(end_left),
    .end_word(end_word),
    .end_cnt (end_cnt)
  );

  sarx_frame_assembler #(.W(SAMPLE_W), .CNT_W(SLOT_CNT_W)) asm_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .fmt_code (fmt_code),
    .end_stb  (end_stb),
    .end_left (end_left),
    .end_word (end_word),
    .end_cnt  (end_cnt),
    .out_ready(out_ready),
    .out_valid(out_valid),
    .out_left (out_left),
    .out_right(out_right),
    .rate_err (rate_err)
  );

endmodule

// File: rtl/sarx_checker.sv
module sarx_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  fmt_code,
  input logic        out_valid,
  input logic        out_ready,
  input logic [23:0] out_left,
  input logic [23:0] out_right,
  input logic        rate_err,
  input logic        fmt_err
);

  // R12
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !rate_err && !fmt_err));

  // R11
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_left) && $stable(out_right)));

  // R9
  fmt_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_code > 3'd4) |=> fmt_err);

  // R9
  fmt_flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_code <= 3'd4) |=> !fmt_err);

  // R9
  fmt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_err && !out_valid) |=> !out_valid);

endmodule

bind serial_audio_rx sarx_checker chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .fmt_code (fmt_code),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_left (out_left),
  .out_right(out_right),
  .rate_err (rate_err),
  .fmt_err  (fmt_err)
);

// File: tb/serial_audio_rx_tb_top.sv
module serial_audio_rx_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_BIT   = 4;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk_in = 1'b0, lrclk_in = 1'b0, sdata_in = 1'b0;
  logic [2:0]  fmt_code = 3'd0;
  logic        lr_pol = 1'b0, bclk_pol = 1'b0;
  logic        out_ready = 1'b1;
  logic        out_valid, rate_err, fmt_err;
  logic [23:0] out_left, out_right;

  int          n_checks = 0;
  int          n_fail = 0;
  bit          data_chk = 1'b1;
  string       cur_req = "R1";
  logic [23:0] q_l[$];
  logic [23:0] q_r[$];
  bit          i2s_mode = 1'b0;
  bit          carry = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_audio_rx dut_i (
    .clk(clk), .rst_n(rst_n), .bclk_in(bclk_in), .lrclk_in(lrclk_in),
    .sdata_in(sdata_in), .fmt_code(fmt_code), .lr_pol(lr_pol),
    .bclk_pol(bclk_pol), .out_valid(out_valid), .out_ready(out_ready),
    .out_left(out_left), .out_right(out_right), .rate_err(rate_err),
    .fmt_err(fmt_err)
  );

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Reference comparison on every clock: each transfer must match the oldest expected pair.
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready && data_chk) begin
      if (q_l.size() == 0) begin
        n_checks++;
        n_fail++;
        $display("FAIL %s R10 unexpected pair: actual %h/%h expected none",
                 cur_req, out_left, out_right);
      end else begin
        check(cur_req, "left sample", out_left, q_l.pop_front());
        check(cur_req, "right sample", out_right, q_r.pop_front());
      end
    end
  end

  function automatic bit ref_rate_ok(input int fc, input int b);
    case (fc)
      0: return b >= 32 && b <= 64;
      1: return b >= 40 && b <= 64;
      2, 4: return b >= 48 && b <= 64;
      3: return b == 32 || (b >= 48 && b <= 64);
      default: return 1'b0;
    endcase
  endfunction

  task automatic clocks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_slot(input bit lvl, input bit gen);
    bit b;
    b = i2s_mode ? carry : gen;
    carry = gen;
    bclk_in = bclk_pol;
    lrclk_in = lvl;
    sdata_in = b;
    clocks(HALF_BIT);
    bclk_in = ~bclk_pol;
    clocks(HALF_BIT);
  endtask

  task automatic send_half(input bit lvl, input bit rj, input int slots,
                           input int n, input logic [23:0] word);
    for (int s = 0; s < slots; s++) begin
      int idx;
      bit g;
      if (rj) begin
        idx = slots - 1 - s;
        g = (idx < n) ? word[idx] : 1'($urandom);
      end else begin
        g = (s < n) ? word[n-1-s] : 1'b0;
      end
      send_slot(lvl, g);
    end
  endtask

  task automatic run_seg(input string req, input int fc, input int bpf, input int nfr,
                         input int wl, input bit lp, input bit bp, input bit chk,
                         input bit hold);
    bit rj, lvl_left;
    int n;
    logic [23:0] first_l, first_r;
    cur_req = req;
    rst_n = 1'b0;
    data_chk = chk;
    fmt_code = 3'(fc);
    lr_pol = lp;
    bclk_pol = bp;
    bclk_in = bp;
    out_ready = !hold;
    i2s_mode = (fc == 3);
    carry = 1'b0;
    clocks(6);
    rst_n = 1'b1;
    clocks(2);
    rj = (fc == 0) || (fc == 1) || (fc == 4);
    n = rj ? ((fc == 0) ? 16 : (fc == 1) ? 20 : 24) : wl;
    lvl_left = (fc == 3) ? lp : ~lp;
    for (int s = 0; s < 5; s++) send_slot(~lvl_left, 1'($urandom));
    for (int f = 0; f < nfr; f++) begin
      logic [23:0] wlft, wrgt, el, er, mask;
      mask = 24'((64'd1 << n) - 1);
      wlft = 24'($urandom) & mask;
      wrgt = 24'($urandom) & mask;
      if (rj) begin
        el = (n < 24 && wlft[n-1]) ? (wlft | ~mask) : wlft;
        er = (n < 24 && wrgt[n-1]) ? (wrgt | ~mask) : wrgt;
      end else begin
        el = wlft << (24 - n);
        er = wrgt << (24 - n);
      end
      if (f == 0) begin
        first_l = el;
        first_r = er;
      end
      if (chk && fc <= 4 && (!hold || f == 0)) begin
        q_l.push_back(el);
        q_r.push_back(er);
      end
      send_half(lvl_left, rj, bpf / 2, n, wlft);
      send_half(~lvl_left, rj, bpf / 2, n, wrgt);
    end
    for (int s = 0; s < 3; s++) send_slot(lvl_left, 1'($urandom));
    clocks(40);
    if (hold) begin
      // R11: first pair held, later frames dropped
      check(req, "R11 valid held", out_valid, 1);
      check(req, "R11 held left", out_left, first_l);
      check(req, "R11 held right", out_right, first_r);
      out_ready = 1'b1;
      clocks(5);
    end
    check(req, "R10 pending pairs", q_l.size(), 0);
    check(req, "R8 rate flag", rate_err, !ref_rate_ok(fc, bpf));
    check(req, "R9 format flag", fmt_err, fc > 4);
    q_l.delete();
    q_r.delete();
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    int wd;
    for (wd = 0; wd < WATCHDOG; wd++) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", wd);
    finish_run();
  end

  initial begin
    clocks(4);
    // R12: reset state
    check("R12", "valid in reset", out_valid, 0);
    check("R12", "rate flag in reset", rate_err, 0);
    check("R12", "format flag in reset", fmt_err, 0);
    //           req                fc bpf nfr wl lp bp chk hold
    run_seg("R1 R2 R4",             0, 32, 3, 16, 0, 0, 1, 0);
    run_seg("R1 R3",                0, 64, 3, 16, 0, 0, 1, 0);
    run_seg("R1 R2 R3",             1, 40, 3, 20, 0, 0, 1, 0);
    run_seg("R1 R3 r24",            4, 48, 3, 24, 0, 0, 1, 0);
    run_seg("R1 R3 r24b",           4, 64, 2, 24, 0, 0, 1, 0);
    run_seg("R1 left aligned",      2, 64, 3, 24, 0, 0, 1, 0);
    run_seg("R5 pad16",             2, 48, 3, 16, 0, 0, 1, 0);
    run_seg("R5 pad20",             3, 64, 2, 20, 0, 0, 1, 0);
    run_seg("R6 i2s64",             3, 64, 3, 24, 0, 0, 1, 0);
    run_seg("R6 i2s32",             3, 32, 3, 16, 0, 0, 1, 0);
    run_seg("R7 i2s inverted",      3, 64, 2, 24, 1, 1, 1, 0);
    run_seg("R7 rj20 inverted",     1, 64, 2, 20, 1, 1, 1, 0);
    run_seg("R7 rj16 lr inverted",  0, 32, 2, 16, 1, 0, 1, 0);
    run_seg("R8 rj24 at 32",        4, 32, 2, 24, 0, 0, 0, 0);
    run_seg("R8 i2s at 40",         3, 40, 2, 24, 0, 0, 0, 0);
    run_seg("R8 rj20 at 36",        1, 36, 2, 20, 0, 0, 0, 0);
    run_seg("R8 lj24 at 46",        2, 46, 2, 24, 0, 0, 0, 0);
    run_seg("R9 code 5",            5, 64, 2, 24, 0, 0, 1, 0);
    run_seg("R9 code 7",            7, 48, 2, 24, 0, 0, 1, 0);
    run_seg("R11 back-pressure",    2, 64, 3, 24, 0, 0, 1, 1);
    finish_run();
  end

endmodule